// File: doc/BRIEF.md
# Transmit Link Fault Sequence Selector

This block sits at the end of the transmit side of a 10G-class Ethernet MAC and chooses, every cycle, what goes out on a 64-bit, eight-lane XGMII-style bus. The bus carries one data byte and one control bit per lane. The block can forward packet beats from an upstream source, or it can send plain IDLE characters, Local Fault ordered sets or Remote Fault ordered sets.

Upstream presents beats with a valid flag, start and end markers, and a byte-enable on the last beat. The block adds a start/preamble cycle in front of each packet and places a terminate character right after the last valid byte. It returns a ready signal that is high only while beats are being taken.

Four control inputs govern the line: a transmit enable, a Local Fault request, a Remote Fault request and a forced-IDLE request. Local Fault wins over Remote Fault, and Remote Fault wins over forced IDLE. None of these requests, nor a drop of the enable, ever splits a frame. Each takes effect on the first cycle after the packet's terminate cycle. The block drives its line outputs from registers, so every line word appears one clock after the cycle in which it was decided.

Top module: `tx_link_seq_sel`

## Requirements
- R1: While reset is held, and at the output after reset, every lane carries 0x07 with its control bit set, and `in_ready` is low.
- R2: While `cfg_enable` is low and no packet is in progress, the line carries only IDLE words, `in_ready` stays low, and no new packet is started even when a start beat is offered.
- R3: While `req_local_fault` is high and no packet is in progress, each 32-bit half of the line carries lane 0 = 0x9C (control) and lanes 1..3 = 0x00, 0x00, 0x01 (data), so the control bus reads 0x11. This holds whatever the other requests and the enable are doing.
- R4: While `req_remote_fault` is high, `req_local_fault` is low and no packet is in progress, the line carries the same pattern as R3 except that the fourth byte of each half is 0x02.
- R5: While `req_idle` is high, neither fault request is active and no packet is in progress, the line carries only IDLE words and `in_ready` stays low.
- R6: With the enable high and no request active, an offered start beat (`in_valid` and `in_sop`) first costs one IDLE decision cycle. It is followed by one word with lane 0 = 0xFB (control), lanes 1..6 = 0x55 and lane 7 = 0xD5 (data, control bus 0x01). After that, beats are accepted with `in_ready` high and are passed through with the control bus at 0x00.
- R7: On an end beat whose `in_keep` marks n < 8 bytes (the set bits are contiguous from lane 0), lanes 0..n-1 carry the data, lane n carries 0xFD (control) and the higher lanes carry 0x07 (control). `in_ready` is low on the next cycle.
- R8: On an end beat with all eight bytes valid, the next line word is a lone terminate: lane 0 = 0xFD and lanes 1..7 = 0x07, all with the control bit set. `in_ready` is low during that cycle.
- R9: A fault or idle request, or a drop of the enable, raised while a packet is in progress does not alter that packet. The request takes effect on the first cycle after the terminate cycle.
- R10: A cycle with `in_valid` low inside a packet puts 0xFE with the control bit set in every lane. The packet then continues with its next beat.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Line clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_enable | input | 1 | Allows new packets to start |
| req_local_fault | input | 1 | Request continuous Local Fault ordered sets |
| req_remote_fault | input | 1 | Request continuous Remote Fault ordered sets |
| req_idle | input | 1 | Request continuous IDLE |
| in_valid | input | 1 | Upstream beat valid |
| in_data | input | 64 | Upstream beat bytes, lane 0 in bits 7:0 |
| in_keep | input | 8 | Byte enables of the end beat, contiguous from lane 0 |
| in_sop | input | 1 | Beat is the first of a packet |
| in_eop | input | 1 | Beat is the last of a packet |
| in_ready | output | 1 | Block takes the offered beat this cycle |
| xg_data | output | 64 | Line data, one byte per lane |
| xg_ctrl | output | 8 | Line control flag, one per lane |

## Verification
The bench first targets the priority ladder. It raises all three requests together, then drops them one at a time. A design with the ladder reversed would show Remote Fault or IDLE where Local Fault belongs. Next it drops the enable and raises Local Fault in the middle of a packet whose last beat is full. A design that acts on requests too early would cut the frame or lose the lone terminate word, and one that acts too late would show IDLE where the fault word is due. Other packets end on one, three and five bytes and contain an inserted gap. These catch a terminate character placed off by one lane, higher lanes left as data, or a gap that ends the packet instead of producing an error word.

// File: rtl/tx_seq_pkg.sv
package tx_seq_pkg;

  // kind of word the selector places on the line this cycle
  typedef enum logic [2:0] {
    K_IDLE,
    K_LFAULT,
    K_RFAULT,
    K_PREAMBLE,
    K_BEAT,
    K_TERM,
    K_GAP
  } word_kind_e;

  typedef enum logic [1:0] {
    ST_OPEN,
    ST_PRE,
    ST_BEAT,
    ST_TAIL
  } seq_state_e;

  localparam logic [7:0] CH_IDLE  = 8'h07;
  localparam logic [7:0] CH_START = 8'hFB;
  localparam logic [7:0] CH_TERM  = 8'hFD;
  localparam logic [7:0] CH_ERR   = 8'hFE;
  localparam logic [7:0] CH_SEQ   = 8'h9C;
  localparam logic [7:0] CH_PRE   = 8'h55;
  localparam logic [7:0] CH_SFD   = 8'hD5;
  localparam logic [7:0] LF_CODE  = 8'h01;
  localparam logic [7:0] RF_CODE  = 8'h02;

endpackage

// File: rtl/tx_seq_fsm.sv
module tx_seq_fsm
  import tx_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_enable,
  input  logic       req_lf,
  input  logic       req_rf,
  input  logic       req_idle,
  input  logic       in_valid,
  input  logic       in_sop,
  input  logic       in_eop,
  input  logic       last_full,
  output logic       in_ready,
  output logic       busy,
  output word_kind_e word_kind
);

  seq_state_e state_q, state_d;

  // next-state and word selection
  always_comb begin
    state_d   = state_q;
    word_kind = K_IDLE;
    in_ready  = 1'b0;
    unique case (state_q)
      ST_OPEN: begin
        if (req_lf) begin
          word_kind = K_LFAULT;
        end else if (req_rf) begin
          word_kind = K_RFAULT;
        end else if (req_idle || !cfg_enable) begin
          word_kind = K_IDLE;
        end else begin
          word_kind = K_IDLE;
          if (in_valid && in_sop) state_d = ST_PRE;
        end
      end
      ST_PRE: begin
        word_kind = K_PREAMBLE;
        state_d   = ST_BEAT;
      end
      ST_BEAT: begin
        in_ready = 1'b1;
        if (in_valid) begin
          word_kind = K_BEAT;
          if (in_eop) state_d = last_full ? ST_TAIL : ST_OPEN;
        end else begin
          word_kind = K_GAP;
        end
      end
      ST_TAIL: begin
        word_kind = K_TERM;
        state_d   = ST_OPEN;
      end
      default: state_d = ST_OPEN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_OPEN;
    else        state_q <= state_d;
  end

  assign busy = (state_q != ST_OPEN);

  // a preamble cycle is always followed by the beat phase with ready high
  assert_pre_then_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !in_ready && $past(!busy) && $past(rst_n)) |=> in_ready);

endmodule

// File: rtl/tx_seq_lanes.sv
module tx_seq_lanes
  import tx_seq_pkg::*;
#(
  parameter int LANES = 8,
  localparam int DW = LANES * 8,
  localparam int CW = $clog2(LANES + 1)
)(
  input  word_kind_e        word_kind,
  input  logic [DW-1:0]     beat_data,
  input  logic [LANES-1:0]  beat_keep,
  input  logic              beat_last,
  output logic [DW-1:0]     word_data,
  output logic [LANES-1:0]  word_ctrl
);

  logic [CW-1:0] nbytes;

  always_comb begin
    nbytes = '0;
    for (int k = 0; k < LANES; k++) begin
      nbytes = nbytes + {{(CW-1){1'b0}}, beat_keep[k]};
    end
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    localparam int POS = i % 4;
    logic [7:0] lane_byte;
    logic       lane_ctl;

    always_comb begin
      lane_byte = CH_IDLE;
      lane_ctl  = 1'b1;
      case (word_kind)
        K_LFAULT, K_RFAULT: begin
          if (POS == 0) begin
            lane_byte = CH_SEQ;
            lane_ctl  = 1'b1;
          end else if (POS == 3) begin
            lane_byte = (word_kind == K_LFAULT) ? LF_CODE : RF_CODE;
            lane_ctl  = 1'b0;
          end else begin
            lane_byte = 8'h00;
            lane_ctl  = 1'b0;
          end
        end
        K_PREAMBLE: begin
          if (i == 0) begin
            lane_byte = CH_START;
            lane_ctl  = 1'b1;
          end else begin
            lane_byte = (i == LANES - 1) ? CH_SFD : CH_PRE;
            lane_ctl  = 1'b0;
          end
        end
        K_BEAT: begin
          if (!beat_last || (CW'(i) < nbytes)) begin
            lane_byte = beat_data[i*8 +: 8];
            lane_ctl  = 1'b0;
          end else if (CW'(i) == nbytes) begin
            lane_byte = CH_TERM;
            lane_ctl  = 1'b1;
          end
        end
        K_TERM: begin
          lane_byte = (i == 0) ? CH_TERM : CH_IDLE;
          lane_ctl  = 1'b1;
        end
        K_GAP: begin
          lane_byte = CH_ERR;
          lane_ctl  = 1'b1;
        end
        default: begin
          lane_byte = CH_IDLE;
          lane_ctl  = 1'b1;
        end
      endcase
    end

    assign word_data[i*8 +: 8] = lane_byte;
    assign word_ctrl[i]        = lane_ctl;
  end

endmodule

// File: rtl/tx_seq_oreg.sv
module tx_seq_oreg
  import tx_seq_pkg::*;
#(
  parameter int LANES = 8,
  localparam int DW = LANES * 8
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DW-1:0]    d_data,
  input  logic [LANES-1:0] d_ctrl,
  output logic [DW-1:0]    q_data,
  output logic [LANES-1:0] q_ctrl
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_data <= {LANES{CH_IDLE}};
      q_ctrl <= '1;
    end else begin
      q_data <= d_data;
      q_ctrl <= d_ctrl;
    end
  end

endmodule

// File: rtl/tx_link_seq_sel.sv
module tx_link_seq_sel
  import tx_seq_pkg::*;
#(
  parameter int LANES = 8,
  localparam int DW = LANES * 8
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_enable,
  input  logic             req_local_fault,
  input  logic             req_remote_fault,
  input  logic             req_idle,
  input  logic             in_valid,
  input  logic [DW-1:0]    in_data,
  input  logic [LANES-1:0] in_keep,
  input  logic             in_sop,
  input  logic             in_eop,
  output logic             in_ready,
  output logic [DW-1:0]    xg_data,
  output logic [LANES-1:0] xg_ctrl
);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_q = rst_sync_q[1];

  word_kind_e       word_kind;
  logic             busy;
  logic             last_full;
  logic [DW-1:0]    nxt_data;
  logic [LANES-1:0] nxt_ctrl;

  assign last_full = in_eop && (&in_keep);

  tx_seq_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_q),
    .cfg_enable (cfg_enable),
    .req_lf     (req_local_fault),
    .req_rf     (req_remote_fault),
    .req_idle   (req_idle),
    .in_valid   (in_valid),
    .in_sop     (in_sop),
    .in_eop     (in_eop),
    .last_full  (last_full),
    .in_ready   (in_ready),
    .busy       (busy),
    .word_kind  (word_kind)
  );

  tx_seq_lanes #(.LANES(LANES)) u_lanes (
    .word_kind (word_kind),
    .beat_data (in_data),
    .beat_keep (in_keep),
    .beat_last (in_eop),
    .word_data (nxt_data),
    .word_ctrl (nxt_ctrl)
  );

  tx_seq_oreg #(.LANES(LANES)) u_oreg (
    .clk    (clk),
    .rst_n  (rst_q),
    .d_data (nxt_data),
    .d_ctrl (nxt_ctrl),
    .q_data (xg_data),
    .q_ctrl (xg_ctrl)
  );

  assert_lf_wins_R3: assert property (@(posedge clk) disable iff (!rst_q)
    (!busy && req_local_fault) |=>
      (xg_data[7:0] == CH_SEQ && xg_ctrl[0] && !xg_ctrl[3] && xg_data[31:24] == LF_CODE));

  assert_rf_next_R4: assert property (@(posedge clk) disable iff (!rst_q)
    (!busy && !req_local_fault && req_remote_fault) |=>
      (xg_data[7:0] == CH_SEQ && xg_ctrl[0] && xg_data[31:24] == RF_CODE));

  assert_idle_only_R5: assert property (@(posedge clk) disable iff (!rst_q)
    (!busy && !req_local_fault && !req_remote_fault && (req_idle || !cfg_enable)) |=>
      (xg_ctrl == '1 && xg_data[7:0] == CH_IDLE));

  assert_no_ready_idle_R2: assert property (@(posedge clk) disable iff (!rst_q)
    (!busy) |-> !in_ready);

  assert_ready_drops_R7: assert property (@(posedge clk) disable iff (!rst_q)
    (in_ready && in_valid && in_eop) |=> !in_ready);

  assert_lone_term_R8: assert property (@(posedge clk) disable iff (!rst_q)
    (in_ready && in_valid && last_full) |=> ##1
      (xg_data[7:0] == CH_TERM && xg_ctrl == '1));

  assert_gap_err_R10: assert property (@(posedge clk) disable iff (!rst_q)
    (in_ready && !in_valid) |=> (xg_ctrl == '1 && xg_data[7:0] == CH_ERR));

endmodule

// File: tb/tx_link_seq_sel_tb.sv
`timescale 1ns/1ps
module tx_link_seq_sel_tb;

  localparam int LANES = 8;

  localparam logic [71:0] W_IDLE = {8'hFF, {8{8'h07}}};
  localparam logic [71:0] W_LF   = {8'h11, 64'h0100009C_0100009C};
  localparam logic [71:0] W_RF   = {8'h11, 64'h0200009C_0200009C};
  localparam logic [71:0] W_PRE  = {8'h01, 64'hD5555555_555555FB};
  localparam logic [71:0] W_TERM = {8'hFF, 64'h07070707_070707FD};
  localparam logic [71:0] W_ERR  = {8'hFF, {8{8'hFE}}};

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_enable, req_local_fault, req_remote_fault, req_idle;
  logic        in_valid, in_sop, in_eop;
  logic [63:0] in_data;
  logic [7:0]  in_keep;
  logic        in_ready;
  logic [63:0] xg_data;
  logic [7:0]  xg_ctrl;

  int n_checks = 0;
  int n_fail   = 0;

  logic [71:0] exp_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;

  tx_link_seq_sel u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable),
    .req_local_fault(req_local_fault), .req_remote_fault(req_remote_fault),
    .req_idle(req_idle), .in_valid(in_valid), .in_data(in_data),
    .in_keep(in_keep), .in_sop(in_sop), .in_eop(in_eop),
    .in_ready(in_ready), .xg_data(xg_data), .xg_ctrl(xg_ctrl)
  );

  function automatic logic [63:0] pat(input int b);
    return {8{8'(8'h10 + b)}} ^ 64'h0123_4567_89AB_CDEF;
  endfunction

  function automatic logic [7:0] thermo(input int n);
    return (n >= 8) ? 8'hFF : 8'((9'h1 << n) - 9'h1);
  endfunction

  function automatic logic [71:0] exp_last(input logic [63:0] d, input int n);
    logic [63:0] od;
    logic [7:0]  oc;
    for (int i = 0; i < 8; i++) begin
      if (i < n)       begin od[i*8 +: 8] = d[i*8 +: 8]; oc[i] = 1'b0; end
      else if (i == n) begin od[i*8 +: 8] = 8'hFD;       oc[i] = 1'b1; end
      else             begin od[i*8 +: 8] = 8'h07;       oc[i] = 1'b1; end
    end
    return {oc, od};
  endfunction

  task automatic check_rdy(input logic exp, input string tag);
    n_checks++;
    if (in_ready !== exp) begin
      n_fail++;
      $display("FAIL %s in_ready actual=%b expected=%b", tag, in_ready, exp);
    end
  endtask

  // driver: inputs already set at a negedge; queue the word due after the next edge
  task automatic step(input logic [71:0] e, input string tag);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(posedge clk);
    @(negedge clk);
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() != 0) begin
        logic [71:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        n_checks++;
        if ({xg_ctrl, xg_data} !== e) begin
          n_fail++;
          $display("FAIL %s line actual=%h expected=%h", t, {xg_ctrl, xg_data}, e);
        end
      end
    end
  end

  // act: 0 plain, 1 drop enable + raise local fault at beat 1, 2 gap before beat 1
  task automatic send_pkt(input int nbeats, input int nlast, input int act, input string tag);
    in_valid = 1'b1; in_sop = 1'b1; in_eop = 1'b0;
    in_data = pat(0); in_keep = 8'hFF;
    check_rdy(1'b0, {tag, " R6 decide"});
    step(W_IDLE, {tag, " R6 decide"});
    check_rdy(1'b0, {tag, " R6 preamble"});
    step(W_PRE, {tag, " R6 preamble"});
    for (int b = 0; b < nbeats; b++) begin
      if (act == 2 && b == 1) begin
        in_valid = 1'b0;
        check_rdy(1'b1, {tag, " R10 gap"});
        step(W_ERR, {tag, " R10 gap"});
        in_valid = 1'b1;
      end
      if (act == 1 && b == 1) begin
        cfg_enable = 1'b0;
        req_local_fault = 1'b1;
      end
      in_sop  = (b == 0);
      in_eop  = (b == nbeats - 1);
      in_data = pat(b);
      in_keep = in_eop ? thermo(nlast) : 8'hFF;
      check_rdy(1'b1, {tag, " R6 beat"});
      if (in_eop) step(exp_last(pat(b), nlast), {tag, " R7 end beat"});
      else        step({8'h00, pat(b)}, {tag, " R6 beat (R9 unchanged)"});
    end
    in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
    if (nlast == 8) begin
      check_rdy(1'b0, {tag, " R8 tail"});
      step(W_TERM, {tag, " R8 tail"});
    end
    check_rdy(1'b0, {tag, " R7 after end"});
    step((act == 1) ? W_LF : W_IDLE, {tag, " R9 after terminate"});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    n_checks++;
    $display("FAIL R1 watchdog actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    cfg_enable = 1'b0; req_local_fault = 1'b0; req_remote_fault = 1'b0; req_idle = 1'b0;
    in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0; in_data = '0; in_keep = '0;
    repeat (3) @(negedge clk);
    n_checks++;
    if ({xg_ctrl, xg_data} !== W_IDLE) begin
      n_fail++;
      $display("FAIL R1 reset line actual=%h expected=%h", {xg_ctrl, xg_data}, W_IDLE);
    end
    check_rdy(1'b0, "R1 reset");
    rst_n = 1'b1;

    // R1/R2: enable low, a start beat offered, only IDLE
    in_valid = 1'b1; in_sop = 1'b1; in_data = pat(9); in_keep = 8'hFF;
    for (int i = 0; i < 5; i++) begin
      check_rdy(1'b0, "R2 disabled");
      step(W_IDLE, "R2 disabled idle");
    end

    // R3: local fault outranks everything
    cfg_enable = 1'b1; req_local_fault = 1'b1; req_remote_fault = 1'b1; req_idle = 1'b1;
    for (int i = 0; i < 3; i++) step(W_LF, "R3 local fault");
    check_rdy(1'b0, "R3 no ready");
    req_local_fault = 1'b0;
    for (int i = 0; i < 2; i++) step(W_RF, "R4 remote fault");
    req_remote_fault = 1'b0;
    for (int i = 0; i < 2; i++) begin
      check_rdy(1'b0, "R5 forced idle");
      step(W_IDLE, "R5 forced idle");
    end
    req_idle = 1'b0;

    send_pkt(2, 3, 0, "P1");
    send_pkt(1, 8, 0, "P2");
    send_pkt(3, 1, 2, "P3");
    send_pkt(2, 5, 0, "P4");
    // R9: enable drop and local fault mid-packet, full last beat
    send_pkt(3, 8, 1, "P5");
    req_local_fault = 1'b0;
    in_valid = 1'b1; in_sop = 1'b1; in_data = pat(4); in_keep = 8'hFF;
    for (int i = 0; i < 3; i++) begin
      check_rdy(1'b0, "R9 R2 no new packet");
      step(W_IDLE, "R9 R2 no new packet");
    end
    in_valid = 1'b0; in_sop = 1'b0;

    repeat (3) @(posedge clk);
    #1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

endmodule